// File: doc/BRIEF.md
# Reloadable Down-Count Tone Timer

This block is an 8-bit down counter that repeats a programmed period and drives a square wave onto an output pin. Software loads the period one 4-bit nibble at a time into a reload buffer. A 4-bit mode register controls three things: the clock rate, which source drives the pin, and whether the counter runs. Each time the count wraps past zero, the counter reloads from the buffer, raises an event flag and toggles a tone flip-flop. The pin therefore carries the count rate divided by twice the period.

The event flag leads to two requests. The interrupt request is the flag gated by an interrupt enable. The hold-release request is the flag gated by a hold-release enable. Four things clear the flag: reset, acceptance of the interrupt, a clear strobe whose mask has the timer bit set, and a restart. When the mode selects it, an externally generated modulation waveform passes straight through to the pin. Everything runs in a single clock domain. A free-running prescaler supplies a one-cycle count enable.

Top module: `tone_timer`

## Requirements
- R1: After a synchronous reset, the counter, the reload buffer, the mode register, the event flag and the tone flip-flop are all 0. Because the mode register is 0, the undivided clock is selected and the timer is stopped.
- R2: A pulse on `rl_lo_wr` stores `rl_data` in reload bits 3:0, and a pulse on `rl_hi_wr` stores it in bits 7:4. Either write clears mode bit 3, so the count stops. The counter keeps its value and does not count on that edge.
- R3: A mode write with `mode_data[3]`=1 and no reload write in the same cycle copies the reload buffer into the counter and clears the event flag on that edge.
- R4: While mode bit 3 is 1, each count enable decrements the counter. An enable that finds the counter at 0 reloads it from the buffer instead and sets the event flag. The flag therefore rises every preset+1 enables.
- R5: With mode bit 0 = 0, the count enable is active on every cycle. With mode bit 0 = 1, it is active only in the cycle where a 6-bit prescaler reads 63. The prescaler starts at 0 at reset and increments on every clock.
- R6: The tone flip-flop toggles on each underflow and holds its value while the timer is stopped.
- R7: `tone_pin` follows the tone flip-flop when mode bit 2 = 1, and follows `mod_in` when mode bit 2 = 0.
- R8: `irq_req` is high exactly when the event flag and `irq_en` are both high. `hold_req` is high exactly when the event flag and `hold_en` are both high.
- R9: The event flag is cleared by `irq_ack`, or by `evt_clr` when `evt_clr_mask[7]` = 1. A clear strobe with mask bit 7 = 0 leaves the flag unchanged.
- R10: If an underflow and a clear request arrive in the same cycle, the flag ends up set.
- R11: Mode bit 1 ignores writes and always reads as 0 on `mode_q[1]`.
- R12: A restart that arrives in the same cycle as an underflow wins: the counter loads the buffer, the flag clears and the tone does not toggle. If a reload write and a start arrive together, the reload write wins: the timer stops and the counter is not loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rl_lo_wr | input | 1 | Write pulse for reload bits 3:0 |
| rl_hi_wr | input | 1 | Write pulse for reload bits 7:4 |
| rl_data | input | 4 | Reload nibble data |
| mode_wr | input | 1 | Mode register write pulse |
| mode_data | input | 4 | Mode data: bit0 prescale, bit2 pin source, bit3 run |
| evt_clr | input | 1 | Masked event clear strobe |
| evt_clr_mask | input | 8 | Clear mask; bit 7 selects this timer |
| irq_ack | input | 1 | Timer interrupt accepted |
| irq_en | input | 1 | Interrupt enable for the timer event |
| hold_en | input | 1 | Hold-release enable for the timer event |
| mod_in | input | 1 | External modulation waveform |
| count_q | output | 8 | Current counter value |
| mode_q | output | 4 | Mode register read value |
| evt_flag | output | 1 | Timer event flag |
| irq_req | output | 1 | Gated interrupt request |
| hold_req | output | 1 | Gated hold-release request |
| tone_pin | output | 1 | Output pin signal |

## Verification
The hardest situations to reach are two collisions: a clear or a restart landing in the exact cycle the counter wraps, and a start arriving together with a reload write. The bench runs a behavioural reference model in lock step with the design. It waits until the model shows a running counter at 0 with a count enable pending, and only then issues the ack, clear or restart on that cycle. The divided-clock mode is exercised over several prescaler periods with a short preset. This lands the 63rd-count enable on a known underflow.

// File: rtl/tone_timer_pkg.sv
// Package: shared widths and the mode-register layout for the tone timer.
// Assumes: the counter is built from whole nibbles.
package tone_timer_pkg;
    localparam int MODE_W      = 4;
    localparam int MB_DIV      = 0;   // prescale select
    localparam int MB_RSV      = 1;   // reserved, reads 0
    localparam int MB_SRC      = 2;   // pin source select
    localparam int MB_RUN      = 3;   // run/stop

    typedef struct packed {
        logic run;
        logic src_tmr;
        logic div_sel;
    } mode_t;
endpackage

// File: rtl/tt_prescale.sv
// Module: free-running prescaler producing a one-cycle count enable.
// Assumes: div_sel comes from a register; when clear, the enable is constant 1.
module tt_prescale #(
    parameter int PRE_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div_sel,
    output logic tick
);
    logic [PRE_W-1:0] pre_q;

    // Advance the prescaler on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // Pick the full-rate enable or the terminal-count pulse.
    always_comb begin
        tick = div_sel ? (&pre_q) : 1'b1;
    end
endmodule

// File: rtl/tt_ctrl.sv
// Module: reload buffer lanes and mode register, with start/halt decode.
// Assumes: a reload write overrides a start in the same cycle.
module tt_ctrl
    import tone_timer_pkg::*;
#(
    parameter int NIB_W = 4,
    parameter int LANES = 2,
    localparam int CNT_W = NIB_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_wr,
    input  logic [NIB_W-1:0]  wr_data,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_data,
    output logic [CNT_W-1:0]  reload_q,
    output mode_t             mode_q,
    output logic              start,
    output logic              halt
);
    logic [NIB_W-1:0] lane_q [LANES];
    logic             any_wr;

    // Reduce the lane strobes to a single "buffer written" flag.
    always_comb begin
        any_wr = |lane_wr;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Capture one nibble of the reload value.
        always_ff @(posedge clk) begin
            if (!rst_n)          lane_q[g] <= '0;
            else if (lane_wr[g]) lane_q[g] <= wr_data;
        end
        assign reload_q[g*NIB_W +: NIB_W] = lane_q[g];
    end

    // Mode register; a buffer write forces run low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            if (mode_wr) begin
                mode_q.div_sel <= mode_data[MB_DIV];
                mode_q.src_tmr <= mode_data[MB_SRC];
                mode_q.run     <= mode_data[MB_RUN];
            end
            if (any_wr) mode_q.run <= 1'b0;
        end
    end

    // Decode restart and immediate-stop events for the counter core.
    always_comb begin
        start = mode_wr & mode_data[MB_RUN] & ~any_wr;
        halt  = any_wr | (mode_wr & ~mode_data[MB_RUN]);
    end
endmodule

// File: rtl/tt_core.sv
// Module: down counter with auto-reload, event flag and tone toggle.
// Assumes: tick is a single-cycle enable; start and halt are already decoded.
module tt_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             start,
    input  logic             halt,
    input  logic [CNT_W-1:0] reload,
    input  logic             clr_hit,
    output logic [CNT_W-1:0] cnt_q,
    output logic             flag_q,
    output logic             tone_q,
    output logic             uflow
);
    logic step;

    // Decide whether this cycle counts and whether it wraps.
    always_comb begin
        step  = run & tick & ~halt & ~start;
        uflow = step & (cnt_q == '0);
    end

    // Load on start, reload on wrap, otherwise decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (start) cnt_q <= reload;
        else if (step)  cnt_q <= uflow ? reload : cnt_q - 1'b1;
    end

    // Event flag: setting takes precedence over every clear source.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag_q <= 1'b0;
        else if (uflow)             flag_q <= 1'b1;
        else if (start || clr_hit)  flag_q <= 1'b0;
    end

    // Divide-by-two tone flip-flop.
    always_ff @(posedge clk) begin
        if (!rst_n)     tone_q <= 1'b0;
        else if (uflow) tone_q <= ~tone_q;
    end
endmodule

// File: rtl/tone_timer.sv
// Module: top of the reloadable tone timer.
// Assumes: one clock domain; all write and clear inputs are single-cycle pulses.
module tone_timer
    import tone_timer_pkg::*;
#(
    parameter int NIB_W    = 4,
    parameter int LANES    = 2,
    parameter int PRE_W    = 6,
    parameter int CLR_W    = 8,
    parameter int CLR_BIT  = 7,
    localparam int CNT_W   = NIB_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rl_lo_wr,
    input  logic              rl_hi_wr,
    input  logic [NIB_W-1:0]  rl_data,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_data,
    input  logic              evt_clr,
    input  logic [CLR_W-1:0]  evt_clr_mask,
    input  logic              irq_ack,
    input  logic              irq_en,
    input  logic              hold_en,
    input  logic              mod_in,
    output logic [CNT_W-1:0]  count_q,
    output logic [MODE_W-1:0] mode_q,
    output logic              evt_flag,
    output logic              irq_req,
    output logic              hold_req,
    output logic              tone_pin
);
    mode_t            mode_r;
    logic [CNT_W-1:0] reload_q;
    logic             start, halt, tick, clr_hit, tone_q, uflow;
    logic [LANES-1:0] lane_wr;

    // Map the two nibble strobes onto the lane vector.
    always_comb begin
        lane_wr    = '0;
        lane_wr[0] = rl_lo_wr;
        lane_wr[LANES-1] = lane_wr[LANES-1] | rl_hi_wr;
        clr_hit    = irq_ack | (evt_clr & evt_clr_mask[CLR_BIT]);
    end

    tt_ctrl #(.NIB_W(NIB_W), .LANES(LANES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .lane_wr(lane_wr), .wr_data(rl_data),
        .mode_wr(mode_wr), .mode_data(mode_data), .reload_q(reload_q),
        .mode_q(mode_r), .start(start), .halt(halt)
    );

    tt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .div_sel(mode_r.div_sel), .tick(tick)
    );

    tt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(mode_r.run),
        .start(start), .halt(halt), .reload(reload_q), .clr_hit(clr_hit),
        .cnt_q(count_q), .flag_q(evt_flag), .tone_q(tone_q), .uflow(uflow)
    );

    // Assemble read-back, request gating and the pin mux.
    always_comb begin
        mode_q         = '0;
        mode_q[MB_DIV] = mode_r.div_sel;
        mode_q[MB_SRC] = mode_r.src_tmr;
        mode_q[MB_RUN] = mode_r.run;
        mode_q[MB_RSV] = 1'b0;
        irq_req        = evt_flag & irq_en;
        hold_req       = evt_flag & hold_en;
        tone_pin       = mode_r.src_tmr ? tone_q : mod_in;
    end
endmodule

// File: rtl/tone_timer_chk.sv
// Module: property checker bound to tone_timer.
// Assumes: observes ports plus the reload buffer, tone flip-flop and wrap signal.
module tone_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rl_lo_wr,
    input logic             rl_hi_wr,
    input logic             mode_wr,
    input logic [3:0]       mode_data,
    input logic             irq_ack,
    input logic [CNT_W-1:0] count_q,
    input logic [3:0]       mode_q,
    input logic             evt_flag,
    input logic             irq_req,
    input logic [CNT_W-1:0] reload_q,
    input logic             tone_q,
    input logic             uflow
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (count_q == '0 && !evt_flag && !tone_q));

    p_write_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rl_lo_wr || rl_hi_wr) |=> !mode_q[3]);

    p_start_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_data[3] && !rl_lo_wr && !rl_hi_wr)
            |=> (count_q == $past(reload_q) && !evt_flag));

    p_flag_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_flag) |-> ($past(count_q) == '0 && $past(mode_q[3])));

    p_tone_on_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tone_q) |-> $past(uflow));

    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> evt_flag);

    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !uflow) |=> !evt_flag);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> evt_flag);
endmodule

bind tone_timer tone_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rl_lo_wr(rl_lo_wr), .rl_hi_wr(rl_hi_wr),
    .mode_wr(mode_wr), .mode_data(mode_data), .irq_ack(irq_ack),
    .count_q(count_q), .mode_q(mode_q), .evt_flag(evt_flag),
    .irq_req(irq_req), .reload_q(reload_q), .tone_q(tone_q), .uflow(uflow)
);

// File: tb/sim_tone_timer.sv
`timescale 1ns/1ps
module sim_tone_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rl_lo_wr = 0, rl_hi_wr = 0, mode_wr = 0, evt_clr = 0, irq_ack = 0;
    logic       irq_en = 0, hold_en = 0, mod_in = 0;
    logic [3:0] rl_data = 0, mode_data = 0;
    logic [7:0] evt_clr_mask = 0;
    logic [7:0] count_q;
    logic [3:0] mode_q;
    logic       evt_flag, irq_req, hold_req, tone_pin;

    int checks = 0;
    int errors = 0;
    string cur = "R1";

    always #2.5 clk = ~clk;

    tone_timer u0 (
        .clk(clk), .rst_n(rst_n), .rl_lo_wr(rl_lo_wr), .rl_hi_wr(rl_hi_wr),
        .rl_data(rl_data), .mode_wr(mode_wr), .mode_data(mode_data),
        .evt_clr(evt_clr), .evt_clr_mask(evt_clr_mask), .irq_ack(irq_ack),
        .irq_en(irq_en), .hold_en(hold_en), .mod_in(mod_in),
        .count_q(count_q), .mode_q(mode_q), .evt_flag(evt_flag),
        .irq_req(irq_req), .hold_req(hold_req), .tone_pin(tone_pin)
    );

    // Behavioural reference model.
    int m_pre, m_buf, m_cnt;
    bit m_run, m_div, m_src, m_flag, m_tog;

    always @(posedge clk) begin
        bit tick, wr, start, halt, step, wrap;
        if (!rst_n) begin
            m_pre = 0; m_buf = 0; m_cnt = 0;
            m_run = 0; m_div = 0; m_src = 0; m_flag = 0; m_tog = 0;
        end else begin
            tick  = !m_div || (m_pre == 63);
            m_pre = (m_pre + 1) % 64;
            wr    = rl_lo_wr || rl_hi_wr;
            start = mode_wr && mode_data[3] && !wr;
            halt  = wr || (mode_wr && !mode_data[3]);
            step  = m_run && tick && !halt && !start;
            wrap  = step && (m_cnt == 0);
            if (start)     m_cnt = m_buf;
            else if (step) m_cnt = wrap ? m_buf : m_cnt - 1;
            if (wrap) m_flag = 1;
            else if (start || irq_ack || (evt_clr && evt_clr_mask[7])) m_flag = 0;
            if (wrap) m_tog = !m_tog;
            if (rl_lo_wr) m_buf = (m_buf & 8'hF0) | rl_data;
            if (rl_hi_wr) m_buf = (m_buf & 8'h0F) | (rl_data << 4);
            if (mode_wr) begin
                m_div = mode_data[0]; m_src = mode_data[2]; m_run = mode_data[3];
            end
            if (wr) m_run = 0;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur, what, act, exp);
        end
    endtask

    // Advance one cycle and compare every output with the model.
    task automatic cyc();
        @(negedge clk);
        chk("count", count_q, m_cnt);
        chk("mode", mode_q, {m_run, m_src, 1'b0, m_div});
        chk("flag", evt_flag, m_flag);
        chk("irq", irq_req, m_flag && irq_en);
        chk("hold", hold_req, m_flag && hold_en);
        chk("pin", tone_pin, m_src ? m_tog : mod_in);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic load(input int v);
        rl_lo_wr = 1; rl_data = v[3:0]; cyc(); rl_lo_wr = 0;
        rl_hi_wr = 1; rl_data = v[7:4]; cyc(); rl_hi_wr = 0;
    endtask

    task automatic mwr(input int v);
        mode_wr = 1; mode_data = v[3:0]; cyc(); mode_wr = 0;
    endtask

    // Stop at a negedge where the next edge wraps the counter.
    task automatic to_wrap();
        int guard = 0;
        while (!(m_run && m_cnt == 0 && (!m_div || m_pre == 63)) && guard < 2000) begin
            cyc(); guard++;
        end
    endtask

    initial begin
        run(3);
        rst_n = 1;
        cur = "R1"; cyc();
        chk("R1 reset count", count_q, 0);
        chk("R1 reset flag", evt_flag, 0);
        chk("R1 reset mode", mode_q, 0);

        cur = "R2"; load(8'h05);
        chk("R2 run cleared", mode_q[3], 0);
        chk("R2 count held", count_q, 0);

        cur = "R3"; mwr(4'b1000);
        chk("R3 loaded", count_q, 5);
        cur = "R4"; run(20);
        chk("R4 flag after wraps", evt_flag, 1);

        cur = "R8"; irq_en = 1; cyc(); hold_en = 1; cyc(); irq_en = 0; cyc(); hold_en = 0; cyc();

        cur = "R9"; mwr(4'b1000); to_wrap(); cyc(); run(1);
        evt_clr = 1; evt_clr_mask = 8'h01; cyc(); evt_clr = 0;
        chk("R9 unmasked clear ignored", evt_flag, 1);
        evt_clr = 1; evt_clr_mask = 8'h80; cyc(); evt_clr = 0;
        chk("R9 masked clear", evt_flag, 0);
        to_wrap(); cyc(); run(1); irq_ack = 1; cyc(); irq_ack = 0;
        chk("R9 ack clear", evt_flag, 0);

        cur = "R10"; to_wrap(); irq_ack = 1; cyc(); irq_ack = 0;
        chk("R10 set wins", evt_flag, 1);

        cur = "R6"; mwr(4'b1100); run(40);
        cur = "R7"; mod_in = 1; cyc(); mwr(4'b1000); cyc(); mod_in = 0; cyc(); mwr(4'b1100);
        cur = "R6"; mwr(4'b0100); run(10);
        chk("R6 held tone", tone_pin, m_tog);

        cur = "R4"; load(8'h00); mwr(4'b1100); run(12);
        load(8'hFF); mwr(4'b1100); run(600);

        cur = "R5"; load(8'h02); mwr(4'b1101); run(900);

        cur = "R11"; mwr(4'b0010);
        chk("R11 reserved reads 0", mode_q, 0);

        cur = "R12"; load(8'h03); mwr(4'b1100); to_wrap();
        mode_wr = 1; mode_data = 4'b1100; cyc(); mode_wr = 0;
        chk("R12 restart no flag", evt_flag, 0);
        chk("R12 restart count", count_q, 3);
        rl_lo_wr = 1; rl_data = 4'h9; mode_wr = 1; mode_data = 4'b1000; cyc();
        rl_lo_wr = 0; mode_wr = 0;
        chk("R12 write beats start", mode_q[3], 0);
        chk("R12 count unchanged", count_q, 3);
        run(5);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule